// File: doc/BRIEF.md
# Float to Saturating Integer Converter

This block turns a floating-point operand that has already been split into its fields into a signed integer of configurable width. The integer part is always taken by truncation toward zero, whatever rounding mode the rest of the datapath uses. Values too large for the target width, along with infinities and NaNs, are clamped to the most positive or most negative integer. Clamping raises an invalid-conversion flag. A separate flag reports that fraction bits were dropped.

The operand has four fields: a two-bit class code, a sign, a signed unbiased exponent and a normalised mantissa. The conversion is combinational. It can be followed by an optional output register of one stage, which is on by default.

Top module: `fp2int_trunc`

## Requirements
- R1: With class code 00 (zero), the result is 0 and both flags are low, whatever the exponent and mantissa hold.
- R2: With class code 01 (number), the operand is `in_mant / 2^(MANT_W-1) * 2^in_exp` and its most significant mantissa bit is the leading one. If the truncated magnitude fits, the result is that magnitude, negated in two's complement when `in_sign` is 1.
- R3: For an in-range number, `out_lost` is 1 exactly when a nonzero mantissa bit lies below the integer part.
- R4: A number with a negative exponent converts to 0, with `out_lost` set if the mantissa is nonzero, and with no invalid flag.
- R5: A number whose exponent is N or larger is out of range: `out_invalid` is 1 and the result saturates.
- R6: A number whose truncated magnitude is at least 2^(N-1)+sign is out of range. So +2^(N-1) saturates, while -2^(N-1) converts exactly to the most negative integer.
- R7: Class codes 10 (infinity) and 11 (NaN) always saturate with `out_invalid` set.
- R8: A saturated result is 2^(N-1)-1 for sign 0 and -2^(N-1) for sign 1, and `out_lost` is 0 whenever `out_invalid` is 1.
- R9: With REG_OUT=1 the outputs follow the inputs with one clock of latency, and an active-low reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| in_class | input | 2 | Class code: 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign | input | 1 | Sign of the operand, 1 = negative |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Normalised mantissa, leading one at the top bit |
| out_int | output | N | Signed integer result |
| out_invalid | output | 1 | Conversion out of range or operand not a number |
| out_lost | output | 1 | Nonzero fraction bits were discarded |

## Verification
The checks run on the default configuration: N=32, MANT_W=67, EXP_W=12, REG_OUT=1. Hand-picked operands cover the following:
- exact and fractional values of both signs, which separate truncation from rounding and show that the lost flag follows only the discarded bits;
- negative exponents, which show the zero result with the flag raised;
- exponents 30, 31 and 32, together with the exact ±2^31 pair, which pin the asymmetric overflow edge;
- infinities and NaNs of both signs, which check the direction of saturation.

A few hundred random operands, weighted toward numbers with exponents on either side of the range, are then compared every clock against a behavioural model built on wide integers. A nonzero input is also held during reset, which shows that the output stage clears.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
    typedef enum logic [1:0] {
        CLS_ZERO = 2'b00,
        CLS_NUM  = 2'b01,
        CLS_INF  = 2'b10,
        CLS_NAN  = 2'b11
    } fp_class_e;
endpackage

// File: rtl/fp2int_align.sv
// Shifts the mantissa so that the integer part lands in the low N bits.
module fp2int_align #(
    parameter int N      = 32,
    parameter int EXP_W  = 12,
    parameter int MANT_W = 67
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [EXP_W-1:0]  exp_i,
    input  logic [MANT_W-1:0]        mant_i,
    output logic [N-1:0]             mag_o,
    output logic                     lost_o,
    output logic                     big_o
);
    localparam int SH_W = $clog2(MANT_W) + 1;

    int                e_int;
    logic [SH_W-1:0]   sh_amt;
    logic [MANT_W-1:0] shifted;
    logic [MANT_W-1:0] low_mask;

    always_comb begin
        e_int    = int'(exp_i);
        big_o    = (e_int >= N);
        sh_amt   = '0;
        if (e_int >= 0 && e_int < N) begin
            sh_amt = SH_W'(MANT_W - 1 - e_int);
        end
        shifted  = mant_i >> sh_amt;
        low_mask = ~({MANT_W{1'b1}} << sh_amt);
        if (e_int < 0) begin
            mag_o  = '0;
            lost_o = |mant_i;
        end else if (big_o) begin
            mag_o  = '0;
            lost_o = 1'b0;
        end else begin
            mag_o  = shifted[N-1:0];
            lost_o = |(mant_i & low_mask);
        end
    end

    AST_LOST_NEEDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mant_i == '0) |-> !lost_o); // R3
    AST_NEG_EXP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(exp_i) < 0) |-> (mag_o == '0)); // R4
endmodule

// File: rtl/fp2int_sat.sv
// Range check, saturation and sign application.
module fp2int_sat
    import fp2int_pkg::*;
#(
    parameter int N = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fp_class_e     cls_i,
    input  logic          sign_i,
    input  logic          big_i,
    input  logic [N-1:0]  mag_i,
    input  logic          lost_i,
    output logic [N-1:0]  res_o,
    output logic          inv_o,
    output logic          lost_o
);
    logic ovf;

    always_comb begin
        ovf    = 1'b0;
        res_o  = '0;
        inv_o  = 1'b0;
        lost_o = 1'b0;
        case (cls_i)
            CLS_ZERO: ;
            CLS_NUM: begin
                if (big_i) begin
                    ovf = 1'b1;
                end else if (mag_i[N-1] && (!sign_i || (|mag_i[N-2:0]))) begin
                    ovf = 1'b1;
                end else begin
                    res_o  = sign_i ? (~mag_i + 1'b1) : mag_i;
                    lost_o = lost_i;
                end
            end
            default: ovf = 1'b1;
        endcase
        if (ovf) begin
            res_o  = {sign_i, {(N-1){~sign_i}}};
            inv_o  = 1'b1;
            lost_o = 1'b0;
        end
    end

    AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_o && res_o != '0) |-> (res_o[N-1] == sign_i)); // R2
    AST_NONNUM_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == CLS_INF || cls_i == CLS_NAN) |-> inv_o); // R7
    AST_TOO_BIG_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == CLS_NUM && big_i) |-> inv_o); // R5
endmodule

// File: rtl/fp2int_trunc.sv
module fp2int_trunc
    import fp2int_pkg::*;
#(
    parameter int N       = 32,
    parameter int EXP_W   = 12,
    parameter int MANT_W  = 67,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               in_class,
    input  logic                     in_sign,
    input  logic signed [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0]        in_mant,
    output logic [N-1:0]             out_int,
    output logic                     out_invalid,
    output logic                     out_lost
);
    typedef struct packed {
        logic [N-1:0] res;
        logic         inv;
        logic         lost;
    } conv_t;

    fp_class_e    cls;
    logic [N-1:0] mag;
    logic         al_lost;
    logic         big;
    conv_t        conv_d;
    conv_t        conv_q;

    assign cls = fp_class_e'(in_class);

    fp2int_align #(.N(N), .EXP_W(EXP_W), .MANT_W(MANT_W)) u_align (
        .clk    (clk),
        .rst_n  (rst_n),
        .exp_i  (in_exp),
        .mant_i (in_mant),
        .mag_o  (mag),
        .lost_o (al_lost),
        .big_o  (big)
    );

    fp2int_sat #(.N(N)) u_sat (
        .clk    (clk),
        .rst_n  (rst_n),
        .cls_i  (cls),
        .sign_i (in_sign),
        .big_i  (big),
        .mag_i  (mag),
        .lost_i (al_lost),
        .res_o  (conv_d.res),
        .inv_o  (conv_d.inv),
        .lost_o (conv_d.lost)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    conv_q <= '0;
                end else begin
                    conv_q <= conv_d;
                end
            end
        end else begin : g_comb
            assign conv_q = conv_d;
        end
    endgenerate

    assign out_int     = conv_q.res;
    assign out_invalid = conv_q.inv;
    assign out_lost    = conv_q.lost;

    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_ZERO) |-> (conv_d.res == '0 && !conv_d.inv && !conv_d.lost)); // R1
    AST_INV_CLEARS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> !out_lost); // R8
endmodule

// File: tb/test_fp2int_trunc.sv
module test_fp2int_trunc;
    localparam int N = 32;
    localparam int EXP_W = 12;
    localparam int MANT_W = 67;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        in_class = 2'b00;
    logic              in_sign = 1'b0;
    logic [EXP_W-1:0]  in_exp = '0;
    logic [MANT_W-1:0] in_mant = '0;
    logic [N-1:0]      out_int;
    logic              out_invalid;
    logic              out_lost;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    fp2int_trunc #(.N(N), .EXP_W(EXP_W), .MANT_W(MANT_W), .REG_OUT(1'b1)) i_fp2int_trunc (
        .clk(clk), .rst_n(rst_n), .in_class(in_class), .in_sign(in_sign),
        .in_exp(in_exp), .in_mant(in_mant),
        .out_int(out_int), .out_invalid(out_invalid), .out_lost(out_lost)
    );

    localparam logic [MANT_W-1:0] ONE = {1'b1, {(MANT_W-1){1'b0}}};

    task automatic compare(input string tag, input logic [N-1:0] er,
                           input logic ei, input logic el);
        n_checks++;
        if (out_int !== er || out_invalid !== ei || out_lost !== el) begin
            n_fail++;
            $display("FAIL %s: got res=%h inv=%b lost=%b, expected res=%h inv=%b lost=%b",
                     tag, out_int, out_invalid, out_lost, er, ei, el);
        end
    endtask

    task automatic run(input logic [1:0] c, input logic s, input int e,
                       input logic [MANT_W-1:0] m, input string tag);
        logic [N-1:0] er;
        logic ei, el, ovf;
        logic [127:0] wide, ip;
        @(negedge clk);
        in_class = c; in_sign = s; in_exp = EXP_W'(e); in_mant = m;
        er = '0; ei = 1'b0; el = 1'b0; ovf = 1'b0;
        wide = 128'(m);
        if (c == 2'b00) begin
            ovf = 1'b0;
        end else if (c != 2'b01) begin
            ovf = 1'b1;
        end else if (e >= N) begin
            ovf = 1'b1;
        end else if (e < 0) begin
            el = (m != '0);
        end else begin
            ip = wide >> (MANT_W - 1 - e);
            el = ((ip << (MANT_W - 1 - e)) != wide);
            if (ip > 128'(2 ** (N - 1) - 1) + 128'(s)) ovf = 1'b1;
            else er = s ? N'(-ip) : N'(ip);
        end
        if (ovf) begin
            er = s ? {1'b1, {(N-1){1'b0}}} : {1'b0, {(N-1){1'b1}}};
            ei = 1'b1;
            el = 1'b0;
        end
        @(posedge clk);
        #1;
        compare(tag, er, ei, el);
    endtask

    function automatic logic [MANT_W-1:0] rnd_mant();
        return {1'b1, $urandom(), $urandom(), 2'($urandom())};
    endfunction

    initial begin
        // R9: reset clears outputs even with a live input
        in_class = 2'b10; in_sign = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        compare("R9 reset", '0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        run(2'b00, 1'b1, 5, rnd_mant(), "R1 zero class");
        run(2'b01, 1'b0, 0, ONE, "R2 +1.0");
        run(2'b01, 1'b1, 0, ONE, "R2 -1.0");
        run(2'b01, 1'b0, 0, ONE | (ONE >> 1), "R3 +1.5");
        run(2'b01, 1'b1, 0, ONE | (ONE >> 1), "R3 -1.5");
        run(2'b01, 1'b0, 3, ONE | (ONE >> 3), "R2 +9 exact");
        run(2'b01, 1'b0, -1, ONE | (ONE >> 1), "R4 0.75");
        run(2'b01, 1'b1, -20, ONE, "R4 tiny negative");
        run(2'b01, 1'b0, 30, {MANT_W{1'b1}}, "R3 max below top");
        run(2'b01, 1'b0, 31, ONE, "R6 +2^31");
        run(2'b01, 1'b1, 31, ONE, "R6 -2^31");
        run(2'b01, 1'b1, 31, ONE | 67'd1 << 35, "R6 below -2^31");
        run(2'b01, 1'b0, 32, ONE, "R5 exp N pos");
        run(2'b01, 1'b1, 100, ONE, "R5 exp big neg");
        run(2'b10, 1'b0, 0, '0, "R7 +inf");
        run(2'b10, 1'b1, 0, '0, "R7 -inf");
        run(2'b11, 1'b0, 7, rnd_mant(), "R8 nan pos");
        run(2'b11, 1'b1, 7, rnd_mant(), "R8 nan neg");

        for (int i = 0; i < 400; i++) begin
            logic [1:0] c;
            c = ($urandom_range(0, 9) < 8) ? 2'b01 : 2'($urandom());
            run(c, 1'($urandom()), $urandom_range(0, 45) - 5, rnd_mant(), "R2 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule